// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block sits inside a storage host controller and moves data between system memory and the controller's data FIFO without processor involvement. Software builds a list of four-word descriptors in memory, each naming up to two data buffers, writes the address of the first descriptor into the engine and starts it. The engine then walks the list on its own.

For each descriptor the engine fetches all four words and checks the ownership flag. It streams the buffer contents out to the FIFO when the transfer goes toward the card, or drains the FIFO into the buffer when data comes from the card. It then hands the descriptor back by rewriting its flags word with the ownership flag cleared. The descriptor flagged as the final one ends the walk and, unless its completion notice is suppressed, raises a transmit-done or receive-done status. A descriptor the engine does not own, or a memory access that reports an error, stops the walk with an abnormal status. Status bits are cleared by writing ones, and one interrupt line combines the enabled completion bits with every abnormal condition.

Top module: `sgdma_engine`

## Requirements
- R1: After reset every register reads zero (control at address 0, list base at 1, status at 2, interrupt enable at 3), and mem_req, fifo_push and fifo_pop are low.
- R2: With to_card high, writing the control register with bit 7 set and bit 0 clear starts a walk at the list base. For each owned descriptor, the words of buffer 1 are read from memory in ascending order and pushed to the FIFO, and no push happens while fifo_full is high. A descriptor occupies four consecutive words: flags, sizes, buffer-1 address, fourth word.
- R3: With to_card low, words are popped from the FIFO only while fifo_empty is low and are written to consecutive buffer addresses in memory.
- R4: When a descriptor's buffers are finished, its flags word is written back to memory with bit 31 (owner) cleared and all other bits unchanged.
- R5: A fetched flags word with bit 31 clear stops the walk without any transfer or write-back and sets status bit 4 (descriptor unavailable).
- R6: Flags bit 4 (chain) set: the fourth word is the next descriptor address. Chain clear: the fourth word is the address of buffer 2, whose byte size sits in sizes bits [31:16], and the next descriptor lies 16 bytes further on, or at the list base when flags bit 5 (end of ring) is set.
- R7: Only after the write-back of a descriptor with flags bit 2 (last) does the walk end and set status bit 0 (to_card high) or bit 1 (to_card low), and neither is set when that descriptor has flags bit 1 (completion notice disable) set.
- R8: A buffer moves ceil(size/4) words, where size is the byte count from the sizes word, and any size above 4096 is treated as 4096.
- R9: Writing a one to a status bit at address 2 clears it, and a zero leaves it.
- R10: Status bit 8 is the OR of bits 0 and 1 each masked by interrupt-enable bits 0 and 1, bit 9 is the OR of bits 2 and 4, and irq is the OR of bits 8 and 9.
- R11: A memory access answered with mem_err stops the walk and sets status bits 2 and 5, and the descriptor is not written back.
- R12: A control write with bit 0 set aborts any walk and clears the status. Bit 0 reads back as zero two cycles later, while control bits 1 and 7, the list base and the enable register keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| to_card | input | 1 | Direction: 1 memory to FIFO, 0 FIFO to memory |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| fifo_push | output | 1 | Push fifo_wdata into the FIFO |
| fifo_wdata | output | 32 | FIFO push data |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_pop | output | 1 | Take fifo_rdata from the FIFO |
| fifo_rdata | input | 32 | FIFO head word, valid while not empty |
| fifo_empty | input | 1 | FIFO has no word |
| irq | output | 1 | Interrupt request |

## Verification
Register reads settle in the same cycle as the address, while a status bit appears one cycle after the memory acknowledge that completes the final write-back, failing fetch or failing access. The bench therefore polls the status register on falling edges until it is nonzero and only then compares status, FIFO traffic and memory contents. A write-one-to-clear or soft reset takes effect on the edge after the write, so those results are read back at least two falling edges later. When no status is expected (completion notice suppressed), the bench waits for the owner bit to clear in its memory model and then allows a few more cycles before checking that the status is still zero.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam logic [1:0] CSR_CTRL   = 2'd0;
    localparam logic [1:0] CSR_BASE   = 2'd1;
    localparam logic [1:0] CSR_STATUS = 2'd2;
    localparam logic [1:0] CSR_IEN    = 2'd3;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_LOAD, W_RD, W_PUSH, W_POP, W_WR, W_WBACK
    } wstate_e;

    // flags word of a descriptor, bit 31 down to bit 0
    typedef struct packed {
        logic        own;
        logic        xfer_err;
        logic [23:0] rsv_hi;
        logic        ring_end;
        logic        chain;
        logic        first;
        logic        last;
        logic        no_notice;
        logic        rsv_lo;
    } dflags_t;

    // number of 32-bit words for a byte count, clipped to the buffer limit
    function automatic logic [15:0] buf_words(input logic [15:0] nbytes,
                                              input logic [15:0] maxb);
        logic [16:0] c;
        c = (nbytes > maxb) ? {1'b0, maxb} : {1'b0, nbytes};
        c = c + 17'd3;
        return {1'b0, c[16:2]};
    endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_wr,
    input  logic [1:0]    csr_addr,
    input  logic [31:0]   csr_wdata,
    output logic [31:0]   csr_rdata,
    input  logic          ev_tx,
    input  logic          ev_rx,
    input  logic          ev_fbe,
    input  logic          ev_du,
    output logic          start,
    output logic          soft_rst,
    output logic [AW-1:0] list_base,
    output logic          irq
);

    logic       fixb, en, srst_q;
    logic [1:0] ien;
    logic       st_tx, st_rx, st_fbe, st_du;
    logic       wr_ctrl, wr_base, wr_st, wr_ie;
    logic       nrm, abn;

    assign wr_ctrl = csr_wr && (csr_addr == CSR_CTRL);
    assign wr_base = csr_wr && (csr_addr == CSR_BASE);
    assign wr_st   = csr_wr && (csr_addr == CSR_STATUS);
    assign wr_ie   = csr_wr && (csr_addr == CSR_IEN);

    assign start    = wr_ctrl && csr_wdata[7] && !csr_wdata[0];
    assign soft_rst = srst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fixb <= 1'b0; en <= 1'b0; srst_q <= 1'b0;
            list_base <= '0; ien <= '0;
            st_tx <= 1'b0; st_rx <= 1'b0; st_fbe <= 1'b0; st_du <= 1'b0;
        end else begin
            srst_q <= wr_ctrl && csr_wdata[0];
            if (wr_ctrl) begin
                fixb <= csr_wdata[1];
                en   <= csr_wdata[7];
            end
            if (wr_base) list_base <= csr_wdata[AW-1:0];
            if (wr_ie)   ien <= csr_wdata[1:0];
            if (srst_q) begin
                st_tx <= 1'b0; st_rx <= 1'b0; st_fbe <= 1'b0; st_du <= 1'b0;
            end else begin
                st_tx  <= (st_tx  && !(wr_st && csr_wdata[0])) || ev_tx;
                st_rx  <= (st_rx  && !(wr_st && csr_wdata[1])) || ev_rx;
                st_fbe <= (st_fbe && !(wr_st && csr_wdata[2])) || ev_fbe;
                st_du  <= (st_du  && !(wr_st && csr_wdata[4])) || ev_du;
            end
        end
    end

    assign nrm = |({st_rx, st_tx} & ien);
    assign abn = st_fbe || st_du;
    assign irq = nrm || abn;

    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            CSR_CTRL:   csr_rdata = {24'd0, en, 5'd0, fixb, srst_q};
            CSR_BASE:   csr_rdata[AW-1:0] = list_base;
            CSR_STATUS: csr_rdata = {22'd0, abn, nrm, 2'd0, st_fbe, st_du,
                                     1'b0, st_fbe, st_rx, st_tx};
            default:    csr_rdata = {30'd0, ien};
        endcase
    end

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_st && csr_wdata[4] && !ev_du) |=> !st_du);

    // R12
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (!st_tx && !st_rx && !st_fbe && !st_du));

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          soft_rst,
    input  logic [AW-1:0] list_base,
    input  logic          to_card,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          fifo_push,
    output logic [31:0]   fifo_wdata,
    input  logic          fifo_full,
    output logic          fifo_pop,
    input  logic [31:0]   fifo_rdata,
    input  logic          fifo_empty,
    output logic          ev_tx,
    output logic          ev_rx,
    output logic          ev_fbe,
    output logic          ev_du
);

    localparam logic [15:0] MAXB = 16'(MAX_BYTES);
    localparam logic [15:0] MAXW = 16'(MAX_BYTES / 4);
    localparam logic [AW-1:0] STEP = AW'(4);
    localparam logic [AW-1:0] DSTRIDE = AW'(16);

    wstate_e     state;
    logic [1:0]  idx;
    logic        bufsel;
    logic [AW-1:0] cur, ptr;
    logic [15:0] rem;
    logic [31:0] d0, d1, d2, d3, dat;
    dflags_t     fl;
    logic [15:0] ld_words;
    logic        ev_done;

    assign fl = dflags_t'(d0);
    assign ld_words = bufsel ? buf_words(d1[31:16], MAXB) : buf_words(d1[15:0], MAXB);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state <= W_IDLE; idx <= '0; bufsel <= 1'b0;
            cur <= '0; ptr <= '0; rem <= '0;
            d0 <= '0; d1 <= '0; d2 <= '0; d3 <= '0; dat <= '0;
        end else begin
            unique case (state)
                W_IDLE: if (start) begin
                    cur <= list_base; idx <= '0; bufsel <= 1'b0;
                    state <= W_FETCH;
                end
                W_FETCH: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin
                        unique case (idx)
                            2'd0: d0 <= mem_rdata;
                            2'd1: d1 <= mem_rdata;
                            2'd2: d2 <= mem_rdata;
                            default: d3 <= mem_rdata;
                        endcase
                        if (idx == 2'd0 && !mem_rdata[31]) state <= W_IDLE;
                        else if (idx == 2'd3) state <= W_LOAD;
                        else idx <= idx + 2'd1;
                    end
                end
                W_LOAD: begin
                    ptr <= bufsel ? d3[AW-1:0] : d2[AW-1:0];
                    rem <= ld_words;
                    if (ld_words != '0) state <= to_card ? W_RD : W_POP;
                    else if (!bufsel && !fl.chain) begin
                        bufsel <= 1'b1; state <= W_LOAD;
                    end else state <= W_WBACK;
                end
                W_RD: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin dat <= mem_rdata; state <= W_PUSH; end
                end
                W_PUSH: if (!fifo_full) begin
                    ptr <= ptr + STEP; rem <= rem - 16'd1;
                    if (rem != 16'd1) state <= W_RD;
                    else if (!bufsel && !fl.chain) begin
                        bufsel <= 1'b1; state <= W_LOAD;
                    end else state <= W_WBACK;
                end
                W_POP: if (!fifo_empty) begin
                    dat <= fifo_rdata; state <= W_WR;
                end
                W_WR: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin
                        ptr <= ptr + STEP; rem <= rem - 16'd1;
                        if (rem != 16'd1) state <= W_POP;
                        else if (!bufsel && !fl.chain) begin
                            bufsel <= 1'b1; state <= W_LOAD;
                        end else state <= W_WBACK;
                    end
                end
                default: if (mem_ack) begin
                    if (mem_err || fl.last) state <= W_IDLE;
                    else begin
                        cur <= fl.chain ? d3[AW-1:0] : (fl.ring_end ? list_base : cur + DSTRIDE);
                        idx <= '0; bufsel <= 1'b0; state <= W_FETCH;
                    end
                end
            endcase
        end
    end

    always_comb begin
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur; mem_wdata = dat;
        fifo_push = 1'b0; fifo_pop = 1'b0; fifo_wdata = dat;
        unique case (state)
            W_FETCH: begin
                mem_req = 1'b1;
                mem_addr = cur + {{(AW-4){1'b0}}, idx, 2'b00};
            end
            W_RD:   begin mem_req = 1'b1; mem_addr = ptr; end
            W_PUSH: fifo_push = !fifo_full;
            W_POP:  fifo_pop = !fifo_empty;
            W_WR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr; end
            W_WBACK: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur;
                mem_wdata = {1'b0, d0[30:0]};
            end
            default: ;
        endcase
    end

    assign ev_fbe  = !soft_rst && mem_req && mem_ack && mem_err;
    assign ev_du   = !soft_rst && state == W_FETCH && idx == 2'd0 && mem_ack
                     && !mem_err && !mem_rdata[31];
    assign ev_done = !soft_rst && state == W_WBACK && mem_ack && !mem_err
                     && fl.last && !fl.no_notice;
    assign ev_tx   = ev_done && to_card;
    assign ev_rx   = ev_done && !to_card;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    unowned_stop_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (state == W_FETCH && idx == 2'd0 && mem_ack && !mem_err && !mem_rdata[31])
        |=> !mem_req);

    // R7
    done_at_wback_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_tx || ev_rx) |-> (mem_req && mem_we && mem_ack && !mem_err));

    // R8
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rem <= MAXW);

    // R11
    bus_err_stop_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (mem_ack && mem_err) |=> !mem_req);

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_wr,
    input  logic [1:0]    csr_addr,
    input  logic [31:0]   csr_wdata,
    output logic [31:0]   csr_rdata,
    input  logic          to_card,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          fifo_push,
    output logic [31:0]   fifo_wdata,
    input  logic          fifo_full,
    output logic          fifo_pop,
    input  logic [31:0]   fifo_rdata,
    input  logic          fifo_empty,
    output logic          irq
);

    logic          start, soft_rst;
    logic [AW-1:0] list_base;
    logic          ev_tx, ev_rx, ev_fbe, ev_du;

    sgdma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_fbe(ev_fbe), .ev_du(ev_du),
        .start(start), .soft_rst(soft_rst), .list_base(list_base), .irq(irq)
    );

    sgdma_walker #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_walk (
        .clk(clk), .rst(rst), .start(start), .soft_rst(soft_rst),
        .list_base(list_base), .to_card(to_card),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_fbe(ev_fbe), .ev_du(ev_du)
    );

    logic unused_wd;
    assign unused_wd = ^{csr_wdata[6:5], csr_wdata[3]};

endmodule

// File: tb/sim_sgdma_engine.sv
module sim_sgdma_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_wr;
    logic [1:0]  csr_addr;
    logic [31:0] csr_wdata, csr_rdata;
    logic        to_card;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fifo_push, fifo_full, fifo_pop, fifo_empty;
    logic [31:0] fifo_wdata, fifo_rdata;
    logic        irq;

    always #5 clk = ~clk;

    sgdma_engine u0 (.*);

    int nchk = 0, nerr = 0;
    int cyc = 0, pcnt = 0, popcnt = 0;
    logic        stall = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFC;
    logic [31:0] mem [0:4095];
    logic [31:0] pushed [0:2047];

    function automatic logic [31:0] pat(input int w);
        return 32'h5A00_0000 + 32'(w) * 32'd7;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_ack && mem_we && !mem_err) mem[mem_addr[13:2]] <= mem_wdata;
        end
        if (fifo_push && !fifo_full && pcnt < 2048) begin
            pushed[pcnt] <= fifo_wdata;
            pcnt <= pcnt + 1;
        end
        if (fifo_pop && !fifo_empty) popcnt <= popcnt + 1;
    end

    assign mem_rdata  = mem[mem_addr[13:2]];
    assign mem_err    = mem_ack && (mem_addr == err_addr);
    assign fifo_full  = stall && (cyc % 5 == 2);
    assign fifo_empty = stall && (cyc % 3 == 1);
    assign fifo_rdata = 32'hC0DE_0000 + 32'(popcnt);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a/4] = w0; mem[a/4+1] = w1; mem[a/4+2] = w2; mem[a/4+3] = w3;
    endtask

    task automatic go(input logic [31:0] base, input logic tx);
        to_card = tx;
        csr_write(2'd1, base);
        csr_write(2'd0, 32'h0000_0080);
    endtask

    task automatic wait_status(output logic [31:0] s);
        s = 0;
        for (int i = 0; i < 20000; i++) begin
            csr_read(2'd2, s);
            if (s != 0) break;
        end
        repeat (3) @(negedge clk);
        csr_read(2'd2, s);
    endtask

    // expected status word from the requirement formulas (R10)
    function automatic logic [31:0] st_exp(input logic [1:0] done, input logic fbe,
                                           input logic du, input logic [1:0] ie);
        return {22'd0, fbe | du, |(done & ie), 2'd0, fbe, du, 1'b0, fbe, done};
    endfunction

    task automatic chk_push(input string req, input int p0, input int w0, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (pushed[p0 + k] !== pat(w0 + k)) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] r, s;
        int p0;
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
        rst = 1'b1; csr_wr = 1'b0; csr_addr = 2'd0; csr_wdata = '0; to_card = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            csr_read(2'(a), r);
            chk("R1 register reset", r, 32'd0);
        end
        chk("R1 idle outputs", {29'd0, mem_req, fifo_push, fifo_pop}, 32'd0);

        // R2 single transmit descriptor, 40 bytes
        csr_write(2'd3, 32'd3);
        put_desc(32'h100, 32'h8000_001C, 32'd40, 32'h1000, 32'd0);
        p0 = pcnt;
        go(32'h100, 1'b1);
        wait_status(s);
        chk("R2 push count", 32'(pcnt - p0), 32'd10);
        chk_push("R2 push data", p0, 32'h400, 10);
        chk("R4 owner returned", mem[32'h40], 32'h0000_001C);
        chk("R7 R10 tx status", s, st_exp(2'b01, 1'b0, 1'b0, 2'b11));
        chk("R10 irq on done", {31'd0, irq}, 32'd1);
        csr_write(2'd2, 32'h0000_0002);
        csr_read(2'd2, r);
        chk("R9 zero leaves bit", r, st_exp(2'b01, 1'b0, 1'b0, 2'b11));
        csr_write(2'd2, 32'h0000_0017);
        csr_read(2'd2, r);
        chk("R9 one clears", r, 32'd0);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);

        // R6 chained list with FIFO back-pressure, 13-byte middle buffer (R8)
        stall = 1'b1;
        put_desc(32'h200, 32'h8000_0018, 32'd8,  32'h1000, 32'h400);
        put_desc(32'h400, 32'h8000_0010, 32'd13, 32'h1010, 32'h300);
        put_desc(32'h300, 32'h8000_0014, 32'd4,  32'h1040, 32'd0);
        p0 = pcnt;
        go(32'h200, 1'b1);
        wait_status(s);
        chk("R6 chain push count", 32'(pcnt - p0), 32'd7);
        chk_push("R6 chain part1", p0, 32'h400, 2);
        chk_push("R8 rounded words", p0 + 2, 32'h404, 4);
        chk_push("R6 chain part3", p0 + 6, 32'h410, 1);
        chk("R4 chain writebacks",
            {mem[32'h80][31], mem[32'h100][31], mem[32'hC0][31]}, 32'd0);
        chk("R7 chain status", s, st_exp(2'b01, 1'b0, 1'b0, 2'b11));
        csr_write(2'd2, 32'h17);

        // R3 receive with empty FIFO stalls
        put_desc(32'h100, 32'h8000_000C, 32'd20, 32'h3000, 32'd0);
        p0 = popcnt;
        go(32'h100, 1'b0);
        wait_status(s);
        begin
            int bad = 0;
            for (int k = 0; k < 5; k++)
                if (mem[32'hC00 + k] !== 32'hC0DE_0000 + 32'(p0 + k)) bad++;
            chk("R3 received words", 32'(bad), 32'd0);
        end
        chk("R3 pop count", 32'(popcnt - p0), 32'd5);
        chk("R7 rx status", s, st_exp(2'b10, 1'b0, 1'b0, 2'b11));
        csr_write(2'd2, 32'h17);
        stall = 1'b0;

        // R6 two buffers in one descriptor
        put_desc(32'h100, 32'h8000_0004, {16'd12, 16'd8}, 32'h1100, 32'h1200);
        p0 = pcnt;
        go(32'h100, 1'b1);
        wait_status(s);
        chk("R6 dual count", 32'(pcnt - p0), 32'd5);
        chk_push("R6 dual first", p0, 32'h440, 2);
        chk_push("R6 dual second", p0 + 2, 32'h480, 3);
        csr_write(2'd2, 32'h17);

        // R6 contiguous next descriptor
        put_desc(32'h500, 32'h8000_0000, 32'd4, 32'h1300, 32'd0);
        put_desc(32'h510, 32'h8000_0004, 32'd4, 32'h1304, 32'd0);
        p0 = pcnt;
        go(32'h500, 1'b1);
        wait_status(s);
        chk_push("R6 contiguous", p0, 32'h4C0, 2);
        chk("R6 contiguous count", 32'(pcnt - p0), 32'd2);
        csr_write(2'd2, 32'h17);

        // R6 end of ring returns to base, which is now host owned (R5)
        put_desc(32'h600, 32'h8000_0020, 32'd4, 32'h1400, 32'd0);
        p0 = pcnt;
        go(32'h600, 1'b1);
        wait_status(s);
        chk("R6 ring count", 32'(pcnt - p0), 32'd1);
        chk("R5 ring stop status", s, st_exp(2'b00, 1'b0, 1'b1, 2'b11));
        chk("R10 irq abnormal", {31'd0, irq}, 32'd1);
        csr_write(2'd2, 32'h17);

        // R5 first descriptor not owned
        put_desc(32'h100, 32'h0000_0004, 32'd8, 32'h1000, 32'd0);
        p0 = pcnt;
        go(32'h100, 1'b1);
        wait_status(s);
        chk("R5 unowned status", s, st_exp(2'b00, 1'b0, 1'b1, 2'b11));
        chk("R5 no transfer", 32'(pcnt - p0), 32'd0);
        chk("R5 no writeback", mem[32'h40], 32'h0000_0004);
        csr_write(2'd2, 32'h17);

        // R7 completion notice suppressed
        put_desc(32'h100, 32'h8000_0006, 32'd8, 32'h1000, 32'd0);
        go(32'h100, 1'b1);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!mem[32'h40][31]) break;
        end
        repeat (4) @(negedge clk);
        csr_read(2'd2, r);
        chk("R7 suppressed notice", r, 32'd0);
        chk("R4 suppressed writeback", mem[32'h40], 32'h0000_0006);

        // R10 done with interrupts disabled
        csr_write(2'd3, 32'd0);
        put_desc(32'h100, 32'h8000_0004, 32'd4, 32'h1000, 32'd0);
        go(32'h100, 1'b1);
        wait_status(s);
        chk("R10 masked summary", s, st_exp(2'b01, 1'b0, 1'b0, 2'b00));
        chk("R10 masked irq", {31'd0, irq}, 32'd0);
        csr_write(2'd2, 32'h17);
        csr_write(2'd3, 32'd3);

        // R8 size above limit is clipped
        put_desc(32'h700, 32'h8000_0004, 32'd5000, 32'h2000, 32'd0);
        p0 = pcnt;
        go(32'h700, 1'b1);
        wait_status(s);
        chk("R8 clipped count", 32'(pcnt - p0), 32'd1024);
        chk_push("R8 clipped data", p0, 32'h800, 1024);
        csr_write(2'd2, 32'h17);

        // R11 bus error on third buffer word
        err_addr = 32'h1008;
        put_desc(32'h100, 32'h8000_001C, 32'd40, 32'h1000, 32'd0);
        p0 = pcnt;
        go(32'h100, 1'b1);
        wait_status(s);
        err_addr = 32'hFFFF_FFFC;
        chk("R11 error status", s, st_exp(2'b00, 1'b1, 1'b0, 2'b11));
        chk("R11 pushes before error", 32'(pcnt - p0), 32'd2);
        chk("R11 no writeback", mem[32'h40], 32'h8000_001C);

        // R12 soft reset mid-transfer, status still set from the error
        put_desc(32'h700, 32'h8000_0004, 32'd5000, 32'h2000, 32'd0);
        go(32'h700, 1'b1);
        repeat (60) @(negedge clk);
        csr_write(2'd0, 32'h0000_0083);
        repeat (2) @(negedge clk);
        chk("R12 request dropped", {31'd0, mem_req}, 32'd0);
        csr_read(2'd0, r);
        chk("R12 control readback", r, 32'h0000_0082);
        csr_read(2'd2, r);
        chk("R12 status cleared", r, 32'd0);
        csr_read(2'd1, r);
        chk("R12 base kept", r, 32'h0000_0700);
        p0 = pcnt;
        repeat (30) @(negedge clk);
        chk("R12 walk aborted", 32'(pcnt - p0), 32'd0);

        report();
    end

endmodule